// File: doc/BRIEF.md
# LCD Controller Power-Up Sequencer

This block brings a 160x104 gray-scale LCD controller out of power-up over a write-only SPI link. After a single-cycle `start` pulse it walks a fixed table of steps. Most steps send one command byte. The others change the chip-select line, pulse the panel reset low, or wait a number of milliseconds. When the table is exhausted the block raises `done` and drops `busy`.

The table is held as tagged entries. Each entry has a 2-bit kind (byte, wait, reset pulse, chip-select level) and an 8-bit argument. Millisecond arguments are timed against the parameter `TICKS_PER_MS`. A small byte shifter inside the block serializes command bytes in SPI mode 0, most significant bit first. Its half-period is set by `HALF_DIV`. The default of 38 cycles at 250 MHz gives a 304 ns SPI clock, which respects the 300 ns minimum.

The controller is a state machine with these states:

- `ST_IDLE`: waiting.
- `ST_FETCH`: decodes the current entry.
- `ST_SHIFT`: waits for the shifter.
- `ST_HOLD`: waits for the millisecond timer.
- `ST_ADVANCE`: steps the index or finishes.

It has these transitions:

- IDLE→FETCH on `start`.
- FETCH→SHIFT on a byte entry.
- FETCH→HOLD on a wait or reset entry.
- FETCH→ADVANCE on a chip-select entry.
- SHIFT→ADVANCE when the byte completes.
- HOLD→ADVANCE when the timer expires.
- ADVANCE→FETCH when entries remain.
- ADVANCE→IDLE after the last entry.

Top module: `lcd_boot_seq`

## Requirements
- R1: Out of reset and whenever idle, `lcd_cs_n`=1, `lcd_rst_n`=1, `spi_sclk`=0, `busy`=0 and `done`=0 (until a first run completes).
- R2: `start` sampled while idle raises `busy` on the next cycle and clears `done`. `start` while busy is ignored and does not restart the run. `done` stays high until the next accepted `start`.
- R3: With chip select deasserted, `lcd_rst_n` is driven low for 18 ms (18·TICKS_PER_MS cycles, up to 2 cycles more). Chip select is asserted only after `lcd_rst_n` returns high.
- R4: Exactly 15 bytes are sent per run, in the order F1, 67, C0, 40, 50, 2B, EB, 81, 5F, 89, A6, D3, AF, A5, A4 (hex).
- R5: The gap from the end of byte AF to the start of A5 is at least 100 ms. The gap from the end of A5 to the start of A4 is at least 200 ms. Each gap exceeds its nominal value by no more than `HALF_DIV`+10 cycles.
- R6: SPI is mode 0 and MSB first. `spi_sclk` idles low and MOSI is stable while `spi_sclk` is high. Rising edges inside a byte are exactly 2·`HALF_DIV` cycles apart.
- R7: `lcd_cs_n` falls exactly once per run and stays low across all 15 bytes. `spi_sclk` never rises while `lcd_cs_n` is high.
- R8: `lcd_dc` is 0 (command) at all times.
- R9: After byte A4, `lcd_cs_n` returns high. `busy` then falls and `done` rises, and no further SPI clock edges occur. `busy` and `done` are never high together.
- R10: A second accepted `start` after completion replays the identical sequence and timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| start | input | 1 | Begin the bring-up sequence (accepted when idle) |
| busy | output | 1 | High while the sequence runs |
| done | output | 1 | High after a completed run until the next start |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_dc | output | 1 | Command/data select, 0 = command |
| lcd_rst_n | output | 1 | Panel reset, active low |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_mosi | output | 1 | SPI serial data, MSB first |

## Verification
The bench times the reset pulse and the two long waits in cycles. A design that miscounted ticks or milliseconds, or used the wrong argument, would land outside the one-tick windows. It fires extra `start` pulses at random points mid-run. A sequencer that restarted on them would emit extra or reordered bytes and more than one chip-select fall. It also watches MOSI while the clock is high and measures the edge spacing. A shifter that sampled on the wrong edge, sent LSB first or miscounted its divider would corrupt the captured bytes or the period. After completion it waits and confirms no stray clock edges and a sticky `done`, then runs the whole sequence a second time.

// File: rtl/lcd_boot_pkg.sv
package lcd_boot_pkg;

    typedef enum logic [1:0] {
        TAG_BYTE  = 2'd0,
        TAG_WAIT  = 2'd1,
        TAG_RESET = 2'd2,
        TAG_CSEL  = 2'd3
    } step_tag_t;

    typedef struct packed {
        step_tag_t  tag;
        logic [7:0] arg;
    } step_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SHIFT,
        ST_HOLD,
        ST_ADVANCE
    } seq_state_t;

    localparam int STEP_COUNT = 21;
    localparam int STEP_IDX_W = $clog2(STEP_COUNT);
    localparam logic DC_COMMAND = 1'b0;

    function automatic step_t mk_step(input step_tag_t t, input logic [7:0] a);
        step_t s;
        s.tag = t;
        s.arg = a;
        return s;
    endfunction

    // Step table; CSEL argument 1 = select the panel.
    function automatic step_t step_at(input logic [STEP_IDX_W-1:0] idx);
        step_t s;
        case (idx)
            5'd0:    s = mk_step(TAG_CSEL,  8'h00);
            5'd1:    s = mk_step(TAG_RESET, 8'd18);
            5'd2:    s = mk_step(TAG_CSEL,  8'h01);
            5'd3:    s = mk_step(TAG_BYTE,  8'hF1);
            5'd4:    s = mk_step(TAG_BYTE,  8'h67);
            5'd5:    s = mk_step(TAG_BYTE,  8'hC0);
            5'd6:    s = mk_step(TAG_BYTE,  8'h40);
            5'd7:    s = mk_step(TAG_BYTE,  8'h50);
            5'd8:    s = mk_step(TAG_BYTE,  8'h2B);
            5'd9:    s = mk_step(TAG_BYTE,  8'hEB);
            5'd10:   s = mk_step(TAG_BYTE,  8'h81);
            5'd11:   s = mk_step(TAG_BYTE,  8'h5F);
            5'd12:   s = mk_step(TAG_BYTE,  8'h89);
            5'd13:   s = mk_step(TAG_BYTE,  8'hA6);
            5'd14:   s = mk_step(TAG_BYTE,  8'hD3);
            5'd15:   s = mk_step(TAG_BYTE,  8'hAF);
            5'd16:   s = mk_step(TAG_WAIT,  8'd100);
            5'd17:   s = mk_step(TAG_BYTE,  8'hA5);
            5'd18:   s = mk_step(TAG_WAIT,  8'd200);
            5'd19:   s = mk_step(TAG_BYTE,  8'hA4);
            default: s = mk_step(TAG_CSEL,  8'h00);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lcd_ms_timer.sv
module lcd_ms_timer #(
    parameter int TICKS_PER_MS = 250000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] ms,
    output logic       expired
);
    localparam int TICK_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS_PER_MS - 1);

    logic [TICK_W-1:0] tick;
    logic [7:0]        ms_left;
    logic              run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick    <= '0;
            ms_left <= '0;
            run     <= 1'b0;
            expired <= 1'b0;
        end else begin
            expired <= 1'b0;
            if (load) begin
                tick    <= '0;
                ms_left <= ms;
                run     <= 1'b1;
            end else if (run) begin
                if (tick == TICK_LAST) begin
                    tick <= '0;
                    if (ms_left <= 8'd1) begin
                        run     <= 1'b0;
                        expired <= 1'b1;
                    end else begin
                        ms_left <= ms_left - 8'd1;
                    end
                end else begin
                    tick <= tick + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lcd_spi_tx.sv
module lcd_spi_tx #(
    parameter int HALF_DIV = 38
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] data,
    output logic       sclk,
    output logic       mosi,
    output logic       done
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    logic [7:0]       shreg;
    logic [DIV_W-1:0] div;
    logic [3:0]       half;
    logic             active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            div    <= '0;
            half   <= '0;
            active <= 1'b0;
            sclk   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                shreg  <= data;
                div    <= '0;
                half   <= '0;
                active <= 1'b1;
                sclk   <= 1'b0;
            end else if (active) begin
                if (div == DIV_LAST) begin
                    div  <= '0;
                    sclk <= ~sclk;
                    half <= half + 4'd1;
                    if (sclk) begin
                        shreg <= {shreg[6:0], 1'b0};
                        if (half == 4'd15) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end
                    end
                end else begin
                    div <= div + 1'b1;
                end
            end
        end
    end

    assign mosi = shreg[7];
endmodule

// File: rtl/lcd_boot_seq.sv
module lcd_boot_seq
    import lcd_boot_pkg::*;
#(
    parameter int HALF_DIV     = 38,
    parameter int TICKS_PER_MS = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic lcd_cs_n,
    output logic lcd_dc,
    output logic lcd_rst_n,
    output logic spi_sclk,
    output logic spi_mosi
);
    localparam logic [STEP_IDX_W-1:0] STEP_LAST = STEP_IDX_W'(STEP_COUNT - 1);

    seq_state_t            state, state_nx;
    logic [STEP_IDX_W-1:0] idx;
    step_t                 cur;
    logic                  last_step;
    logic                  spi_load, spi_done;
    logic                  tmr_load, tmr_expired;

    lcd_spi_tx #(.HALF_DIV(HALF_DIV)) i_spi (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (spi_load),
        .data  (cur.arg),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .done  (spi_done)
    );

    lcd_ms_timer #(.TICKS_PER_MS(TICKS_PER_MS)) i_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .ms      (cur.arg),
        .expired (tmr_expired)
    );

    assign cur       = step_at(idx);
    assign last_step = (idx == STEP_LAST);
    assign lcd_dc    = DC_COMMAND;

    // State register and step index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start)
                idx <= '0;
            else if (state == ST_ADVANCE && !last_step)
                idx <= idx + 1'b1;
        end
    end

    // Next state and sub-unit launches
    always_comb begin
        state_nx = state;
        spi_load = 1'b0;
        tmr_load = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) state_nx = ST_FETCH;
            end
            ST_FETCH: begin
                unique case (cur.tag)
                    TAG_BYTE: begin
                        spi_load = 1'b1;
                        state_nx = ST_SHIFT;
                    end
                    TAG_WAIT, TAG_RESET: begin
                        tmr_load = 1'b1;
                        state_nx = ST_HOLD;
                    end
                    TAG_CSEL: state_nx = ST_ADVANCE;
                endcase
            end
            ST_SHIFT: begin
                if (spi_done) state_nx = ST_ADVANCE;
            end
            ST_HOLD: begin
                if (tmr_expired) state_nx = ST_ADVANCE;
            end
            ST_ADVANCE: begin
                state_nx = last_step ? ST_IDLE : ST_FETCH;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            lcd_cs_n  <= 1'b1;
            lcd_rst_n <= 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        busy     <= 1'b1;
                        done     <= 1'b0;
                        lcd_cs_n <= 1'b1;
                    end
                end
                ST_FETCH: begin
                    if (cur.tag == TAG_CSEL)  lcd_cs_n  <= ~cur.arg[0];
                    if (cur.tag == TAG_RESET) lcd_rst_n <= 1'b0;
                end
                ST_HOLD: begin
                    if (tmr_expired) lcd_rst_n <= 1'b1;
                end
                ST_ADVANCE: begin
                    if (last_step) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lcd_boot_seq_chk.sv
module lcd_boot_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic lcd_cs_n,
    input logic lcd_rst_n,
    input logic spi_sclk,
    input logic spi_mosi
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!spi_sclk && lcd_rst_n)); // R1
    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy); // R2
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R2
    AST_RST_WITH_CS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_rst_n |-> lcd_cs_n); // R3
    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R6
    AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !lcd_cs_n); // R7
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R9
endmodule

bind lcd_boot_seq lcd_boot_seq_chk i_lcd_boot_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .lcd_cs_n  (lcd_cs_n),
    .lcd_rst_n (lcd_rst_n),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi)
);

// File: tb/test_lcd_boot_seq.sv
`timescale 1ns/1ps
module test_lcd_boot_seq;
    localparam int HD  = 38;
    localparam int TPM = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, done, lcd_cs_n, lcd_dc, lcd_rst_n, spi_sclk, spi_mosi;

    always #2 clk = ~clk;

    lcd_boot_seq #(.HALF_DIV(HD), .TICKS_PER_MS(TPM)) i_lcd_boot_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .lcd_cs_n(lcd_cs_n), .lcd_dc(lcd_dc), .lcd_rst_n(lcd_rst_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor state
    int nb, bitn, last_rise, per_err, mode_err, cs_err, dc_err, cs_fall;
    int cs_fall_cyc, cs_rise_cyc, rst_fall, rst_rise;
    int bstart [0:31];
    int bend   [0:31];
    logic [7:0] bval [0:31];
    logic [7:0] sh;
    logic sclk_q = 1'b0, mosi_q = 1'b0, cs_q = 1'b1, rst_q = 1'b1;

    function automatic logic [7:0] exp_byte(input int k);
        case (k)
            0: return 8'hF1;  1: return 8'h67;  2: return 8'hC0;
            3: return 8'h40;  4: return 8'h50;  5: return 8'h2B;
            6: return 8'hEB;  7: return 8'h81;  8: return 8'h5F;
            9: return 8'h89; 10: return 8'hA6; 11: return 8'hD3;
           12: return 8'hAF; 13: return 8'hA5; 14: return 8'hA4;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic clear_mon();
        nb = 0; bitn = 0; last_rise = 0; per_err = 0; mode_err = 0;
        cs_err = 0; dc_err = 0; cs_fall = 0; cs_fall_cyc = 0;
        cs_rise_cyc = 0; rst_fall = 0; rst_rise = 0; sh = '0;
    endtask

    always @(negedge clk) begin
        if (lcd_dc !== 1'b0) dc_err++;
        if (spi_sclk && !sclk_q) begin
            if (lcd_cs_n) cs_err++;
            if (bitn != 0 && (cyc - last_rise) != 2 * HD) per_err++;
            if (bitn == 0 && nb < 32) bstart[nb] = cyc;
            last_rise = cyc;
            sh = {sh[6:0], spi_mosi};
            bitn++;
            if (bitn == 8) begin
                if (nb < 32) bval[nb] = sh;
                bitn = 0;
                nb++;
            end
        end
        if (!spi_sclk && sclk_q && bitn == 0 && nb > 0 && nb <= 32) bend[nb-1] = cyc;
        if (spi_sclk && sclk_q && spi_mosi !== mosi_q) mode_err++;
        if (!lcd_cs_n && cs_q) begin cs_fall++; cs_fall_cyc = cyc; end
        if (lcd_cs_n && !cs_q) cs_rise_cyc = cyc;
        if (!lcd_rst_n && rst_q) rst_fall = cyc;
        if (lcd_rst_n && !rst_q) rst_rise = cyc;
        sclk_q = spi_sclk; mosi_q = spi_mosi; cs_q = lcd_cs_n; rst_q = lcd_rst_n;
    end

    task automatic run_seq(input string rtag);
        int n;
        int g;
        clear_mon();
        repeat ($urandom_range(1, 20)) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, {"R2 busy after start ", rtag}, busy, 1);
        chk(done == 1'b0, {"R2 done cleared ", rtag}, done, 0);
        // Stray start pulses while busy (must be ignored, R2)
        while (!done) begin
            n = $urandom_range(200, 3000);
            repeat (n) begin
                @(negedge clk);
                if (done) break;
            end
            if (!done) begin
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        end
        repeat (600) @(negedge clk);
        chk(done == 1'b1 && busy == 1'b0, {"R9 done/busy at end ", rtag}, {done, busy}, 2);
        chk(nb == 15, {"R4 byte count ", rtag}, nb, 15);
        for (int k = 0; k < 15; k++)
            chk(bval[k] == exp_byte(k), {"R4 byte order ", rtag}, bval[k], exp_byte(k));
        g = rst_rise - rst_fall;
        chk(g >= 18 * TPM && g <= 18 * TPM + 2, {"R3 reset width ", rtag}, g, 18 * TPM);
        chk(rst_fall > 0 && cs_fall_cyc > rst_rise, {"R3 cs after reset ", rtag}, cs_fall_cyc, rst_rise);
        g = bstart[13] - bend[12];
        chk(g >= 100 * TPM && g <= 100 * TPM + HD + 10, {"R5 gap after AF ", rtag}, g, 100 * TPM);
        g = bstart[14] - bend[13];
        chk(g >= 200 * TPM && g <= 200 * TPM + HD + 10, {"R5 gap after A5 ", rtag}, g, 200 * TPM);
        chk(per_err == 0, {"R6 sclk period ", rtag}, per_err, 0);
        chk(mode_err == 0, {"R6 mosi stable while sclk high ", rtag}, mode_err, 0);
        chk(bitn == 0, {"R6 whole bytes ", rtag}, bitn, 0);
        chk(cs_fall == 1, {"R7 single cs assertion ", rtag}, cs_fall, 1);
        chk(cs_err == 0, {"R7 sclk with cs high ", rtag}, cs_err, 0);
        chk(dc_err == 0, {"R8 dc command ", rtag}, dc_err, 0);
        chk(lcd_cs_n == 1'b1 && cs_rise_cyc > bend[14], {"R9 cs released ", rtag}, cs_rise_cyc, bend[14]);
        chk(spi_sclk == 1'b0 && lcd_rst_n == 1'b1, {"R1 idle lines ", rtag}, {spi_sclk, lcd_rst_n}, 1);
    endtask

    initial begin
        void'($urandom(32'h1CD5_0B07));
        clear_mon();
        repeat (5) @(negedge clk);
        chk(lcd_cs_n == 1'b1, "R1 cs_n in reset", lcd_cs_n, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(lcd_cs_n == 1'b1 && lcd_rst_n == 1'b1, "R1 panel lines idle", {lcd_cs_n, lcd_rst_n}, 3);
        chk(spi_sclk == 1'b0, "R1 sclk idle", spi_sclk, 0);
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done idle", {busy, done}, 0);
        chk(lcd_dc == 1'b0, "R8 dc idle", lcd_dc, 0);
        run_seq("R2 run1");
        chk(done == 1'b1, "R2 done sticky before restart", done, 1);
        run_seq("R10 rerun");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule